// File: doc/BRIEF.md
# Sigma-Delta Fractional Modulus Controller

This block selects, once per divider output period, the divide ratio that a dual-modulus feedback divider in a fractional-N frequency synthesizer should use for its next cycle. The integer part N and an unsigned fraction `frac` (weight frac/2^FRAC_W) are static control inputs. Each pulse on `step_i` advances a digital sigma-delta loop once and registers a new ratio N + offset. Over many cycles the ratios average to N + frac/2^FRAC_W, and the quantization error is pushed toward high frequencies, where the analog loop filter removes it.

Two loop variants share the outputs. In first-order mode a delaying integrator feeds a two-level quantizer, so the offset is 0 or 1 and the error is shaped by (1 - z^-1). In second-order mode an error-feedback loop with a four-level rounding quantizer gives (1 - z^-1)^2 shaping. Its offset lies in -1..+2, and the fraction passes to the output without delay. The integer part must be at least 1 so that N - 1 stays non-negative.

Top module: `fracn_modsel`

## Requirements
- R1: While `rst_n` is low and after reset, `offset_o` is 0, `ratio_o` is 0 and all loop state is cleared.
- R2: In first-order mode (`mode_i` = 0) every registered offset is 0 or 1, so `ratio_o` is N or N+1.
- R3: In first-order mode the sum of the offsets over any 2^FRAC_W consecutive steps with constant `frac` lies within 2 of `frac`.
- R4: The first-order loop delays: from cleared state the first step gives offset 0 whatever `frac` is. With `frac` = 2^(FRAC_W-1) the ratios run N, N+1, N, N+1, ... from reset.
- R5: In second-order mode (`mode_i` = 1) every offset lies in -1..+2, and the sum over any 2^FRAC_W consecutive steps lies within 2 of `frac`.
- R6: The second-order loop does not delay: from cleared state the first step gives offset 1 when `frac` is at least 2^(FRAC_W-1).
- R7: With `frac` = 0 and cleared state the ratio stays N indefinitely in both modes.
- R8: Without a `step_i` pulse, `ratio_o` and `offset_o` keep their values, even if N, `frac` or `mode_i` change.
- R9: After a step, `ratio_o` equals the N sampled at that step plus the sign-extended offset. It changes on the clock edge where `step_i` is high and is valid from the following cycle.
- R10: A new `frac` takes effect at the next step without clearing the loop state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | One-cycle pulse per divider output period; advances the loop |
| mode_i | input | 1 | 0: first-order, two-level; 1: second-order, four-level |
| int_i | input | INT_W | Integer part N of the divide ratio (N >= 1) |
| frac_i | input | FRAC_W | Unsigned fraction, weight frac/2^FRAC_W |
| ratio_o | output | INT_W+1 | Registered divide ratio N + offset |
| offset_o | output | 3 | Registered signed offset added to N |

## Verification
On every cycle the assertions check the following: the offset stays within its signed range, and it stays two-level in first-order mode. Both loops' state stays inside its bounded range without wrap. The outputs hold between steps, and the ratio always equals the sampled N plus the offset. Only the bench's scenarios can show the behaviour over many steps. These cover the average over 2^FRAC_W steps, the strict alternation at one half, and the constant output at zero fraction. They also show the one-step difference in latency between the delaying and non-delaying loops, and that a new fraction takes effect without reset.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
    typedef enum logic {
        ORDER_ONE = 1'b0,
        ORDER_TWO = 1'b1
    } order_e;

    typedef logic signed [2:0] ofs_t;
endpackage

// File: rtl/sdm_order1.sv
module sdm_order1 #(
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              bit_o
);
    localparam int ACC_W = FRAC_W + 2;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 << (FRAC_W - 1));
    localparam logic signed [ACC_W-1:0] FULL = ACC_W'(1 << FRAC_W);
    localparam logic signed [ACC_W-1:0] LO   = -HALF;
    localparam logic signed [ACC_W-1:0] HI   = FULL + HALF;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } st_t;

    st_t s_d, s_q;
    logic signed [ACC_W-1:0] acc_s;
    logic signed [ACC_W-1:0] fx;

    always_comb begin
        acc_s = $signed(s_q.acc);
        fx    = $signed({2'b00, frac_i});
        bit_o = (acc_s >= HALF);
        s_d   = s_q;
        if (upd_i) begin
            s_d.acc = acc_s + fx - (bit_o ? FULL : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R3: integrator stays inside its range, no wrap
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(s_q.acc) >= LO) && ($signed(s_q.acc) < HI));
endmodule

// File: rtl/sdm_order2.sv
module sdm_order2 #(
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [FRAC_W-1:0] frac_i,
    output fracn_pkg::ofs_t   ofs_o
);
    localparam int ACC_W = FRAC_W + 2;
    localparam int U_W   = FRAC_W + 3;
    localparam logic signed [U_W-1:0]   HALF_U = U_W'(1 << (FRAC_W - 1));
    localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(1 << (FRAC_W - 1));
    localparam logic signed [ACC_W-1:0] LO     = -HALF;

    typedef struct packed {
        logic [ACC_W-1:0] e1;
        logic [ACC_W-1:0] e2;
    } st_t;

    st_t s_d, s_q;
    logic signed [U_W-1:0] fx, e1x, e2x, u, r, q, e;

    always_comb begin
        fx    = $signed({3'b000, frac_i});
        e1x   = $signed({s_q.e1[ACC_W-1], s_q.e1});
        e2x   = $signed({s_q.e2[ACC_W-1], s_q.e2});
        u     = fx + (e1x <<< 1) - e2x;
        r     = u + HALF_U;
        q     = r >>> FRAC_W;
        e     = u - (q <<< FRAC_W);
        ofs_o = q[2:0];
        s_d   = s_q;
        if (upd_i) begin
            s_d.e1 = e[ACC_W-1:0];
            s_d.e2 = s_q.e1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R5: stored errors stay within half a quantizer step
    a_r5_err_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(s_q.e1) >= LO) && ($signed(s_q.e1) < HALF) &&
        ($signed(s_q.e2) >= LO) && ($signed(s_q.e2) < HALF));
endmodule

// File: rtl/fracn_modsel.sv
module fracn_modsel
    import fracn_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_i,
    input  logic                    mode_i,
    input  logic [INT_W-1:0]        int_i,
    input  logic [FRAC_W-1:0]       frac_i,
    output logic [INT_W:0]          ratio_o,
    output logic signed [2:0]       offset_o
);
    localparam int RAT_W = INT_W + 1;

    typedef struct packed {
        logic [2:0]       ofs;
        logic [RAT_W-1:0] ratio;
    } out_t;

    out_t   o_d, o_q;
    order_e order;
    logic   upd1, upd2, bit1;
    ofs_t   ofs2;

    assign order = order_e'(mode_i);
    assign upd1  = step_i && (order == ORDER_ONE);
    assign upd2  = step_i && (order == ORDER_TWO);

    sdm_order1 #(.FRAC_W(FRAC_W)) i_ord1 (
        .clk(clk), .rst_n(rst_n), .upd_i(upd1), .frac_i(frac_i), .bit_o(bit1)
    );

    sdm_order2 #(.FRAC_W(FRAC_W)) i_ord2 (
        .clk(clk), .rst_n(rst_n), .upd_i(upd2), .frac_i(frac_i), .ofs_o(ofs2)
    );

    always_comb begin
        o_d = o_q;
        if (step_i) begin
            o_d.ofs   = (order == ORDER_TWO) ? ofs2 : {2'b00, bit1};
            o_d.ratio = {1'b0, int_i} + {{(RAT_W-3){o_d.ofs[2]}}, o_d.ofs};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign ratio_o  = o_q.ratio;
    assign offset_o = $signed(o_q.ofs);

    // R5: offset confined to -1..+2
    a_r5_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
        (offset_o >= -3'sd1) && (offset_o <= 3'sd2));

    // R2: first-order steps produce a two-level offset
    a_r2_two_level: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !mode_i) |=> (offset_o == 3'sd0 || offset_o == 3'sd1));

    // R8: outputs hold between steps
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(ratio_o) && $stable(offset_o)));

    // R9: ratio equals the sampled N plus the signed offset
    a_r9_ratio_sum: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (ratio_o == ({1'b0, $past(int_i)} +
                     {{(RAT_W-3){offset_o[2]}}, offset_o})));
endmodule

// File: tb/test_fracn_modsel.sv
module test_fracn_modsel;
    localparam int INT_W  = 8;
    localparam int FRAC_W = 8;
    localparam int PERIOD = 1 << FRAC_W;
    localparam int HALFV  = 1 << (FRAC_W - 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               step = 1'b0;
    logic               mode = 1'b0;
    logic [INT_W-1:0]   nval = 8'd20;
    logic [FRAC_W-1:0]  frac = '0;
    logic [INT_W:0]     ratio;
    logic signed [2:0]  offs;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    fracn_modsel #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_fracn_modsel (
        .clk(clk), .rst_n(rst_n), .step_i(step), .mode_i(mode),
        .int_i(nval), .frac_i(frac), .ratio_o(ratio), .offset_o(offs)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_step(output int r, output int o);
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        r = int'(ratio);
        o = int'(offs);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ratio == 0 && offs == 0, "R1 during reset", int'(ratio), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ratio == 0 && offs == 0, "R1 after reset", int'(ratio), 0);
    endtask

    task automatic t_zero(input bit m);
        int r, o, wrong;
        do_reset();
        mode = m; frac = '0; wrong = 0;
        for (int i = 0; i < 40; i++) begin
            do_step(r, o);
            if (r != int'(nval)) wrong++;
        end
        chk(wrong == 0, "R7 zero fraction holds N", wrong, 0);
    endtask

    task automatic t_half();
        int r, o, wrong;
        do_reset();
        mode = 1'b0; frac = FRAC_W'(HALFV); wrong = 0;
        for (int i = 0; i < 10; i++) begin
            do_step(r, o);
            if (r != int'(nval) + (i % 2)) wrong++;
        end
        chk(wrong == 0, "R4 half alternates N,N+1", wrong, 0);
        // R10: switch fraction without reset; state is back at zero
        frac = '0; wrong = 0;
        for (int i = 0; i < 8; i++) begin
            do_step(r, o);
            if (r != int'(nval)) wrong++;
        end
        chk(wrong == 0, "R10 new fraction applies at next step", wrong, 0);
    endtask

    task automatic t_avg(input bit m, input int f, input string tag);
        int r, o, sum, badlvl;
        mode = m; frac = FRAC_W'(f); sum = 0; badlvl = 0;
        for (int i = 0; i < PERIOD; i++) begin
            do_step(r, o);
            sum += o;
            if (m == 1'b0 && !(o == 0 || o == 1)) badlvl++;
            if (m == 1'b1 && (o < -1 || o > 2)) badlvl++;
            if (r != int'(nval) + o) badlvl++;
        end
        chk(badlvl == 0, {tag, " offset levels"}, badlvl, 0);
        chk(sum >= f - 2 && sum <= f + 2, {tag, " average"}, sum, f);
    endtask

    task automatic t_latency();
        int r, o;
        do_reset();
        mode = 1'b0; frac = 8'd200;
        do_step(r, o);
        chk(o == 0, "R4 first-order delays one step", o, 0);
        do_reset();
        mode = 1'b1; frac = '0;
        do_step(r, o);
        do_step(r, o);
        frac = 8'd200;
        do_step(r, o);
        chk(o == 1, "R6 second-order passes fraction at once", o, 1);
        chk(r == int'(nval) + 1, "R9 ratio is N plus offset", r, int'(nval) + 1);
    endtask

    task automatic t_hold();
        int r, o, r0;
        do_reset();
        mode = 1'b0; frac = FRAC_W'(HALFV);
        do_step(r, o);
        do_step(r, o);
        r0 = r;
        nval = 8'd33; frac = 8'd5; mode = 1'b1;
        repeat (6) @(negedge clk);
        chk(int'(ratio) == r0 && offs == 1, "R8 no step keeps outputs", int'(ratio), r0);
        do_step(r, o);
        chk(r == 33 + o, "R9 uses N sampled at step", r, 33 + o);
        nval = 8'd20;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_zero(1'b0);
        t_zero(1'b1);
        t_half();
        t_latency();
        t_hold();
        do_reset();
        t_avg(1'b0, 1,   "R2 R3 f=1");
        t_avg(1'b0, 77,  "R2 R3 f=77");
        t_avg(1'b0, 255, "R2 R3 f=255");
        do_reset();
        t_avg(1'b1, 77,  "R5 f=77");
        t_avg(1'b1, 250, "R5 f=250");
        t_avg(1'b1, 3,   "R5 f=3");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule